// File: doc/BRIEF.md
# Three-Channel DMA Bus Arbiter

This block decides which of three DMA channels may use a shared memory bus, and it runs the bus cycles for the winner. Each channel raises a level request while it has work pending. The requests are synchronized, and one winner is chosen by either a fixed order or a rotating order. The sequencer then drives one read cycle, one write cycle and one trailing wait cycle. The CPU is stalled with a bus-hold signal for those three cycles. A request that is still pending when the wait cycle is reached is granted again at once, so a channel that keeps its request high is served every three cycles when the bus is ready.

Two controls change when a transfer may begin or end. With fetch gating on, a granted channel waits until the CPU signals an instruction fetch, and only then takes the bus. With the NMI enable set, a non-maskable interrupt that arrives during the read or write cycle ends the transfer. The grant is then dropped and a one-cycle abort pulse names the channel that was cut off. An NMI without the enable has no effect, and neither does an NMI during the wait cycle.

Top module: `dma_tri_arbiter`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `grant`, `bus_hold`, `bus_rd`, `bus_wr` and `abort` are all zero.
- R2: Requests pass through a two-flop synchronizer. With fetch gating off, a request applied before rising edge 1 produces its first read cycle after rising edge 3, and no earlier.
- R3: With `rotate_en` low, the grant always goes to the lowest-numbered pending channel. Bit i of `chan_req`, `grant` and `abort` belongs to channel i.
- R4: With `rotate_en` high, the channel that completes a transfer drops to lowest priority and the other two each move up one place. After reset, channel 0 is highest.
- R5: `grant` is one-hot or zero. It does not change from the first read cycle until the wait cycle, unless the transfer is aborted.
- R6: Each transfer is a read cycle (`bus_rd`), then a write cycle (`bus_wr`), then exactly one wait cycle with both low. The read and write cycles each last until `bus_done` is high.
- R7: `bus_hold` is high in the read, write and wait cycles, and low while the block is idle or waiting for a fetch.
- R8: With `fetch_gate_en` high, the grant is shown but the read cycle is held back, with `bus_hold` low. The read cycle starts in the cycle after the one in which `fetch_stb` is high.
- R9: If `nmi` and `nmi_en` are both high during a read or write cycle, the next cycle has `grant` zero, `bus_hold` low, and `abort` equal to the aborted grant. `abort` is zero in the cycle after that.
- R10: An `nmi` with `nmi_en` low does not stop the transfer, and `abort` stays zero.
- R11: If a request is pending during the wait cycle, the next read cycle follows the wait cycle directly. This gives a cadence of three cycles per transfer when `bus_done` is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_req | input | 3 | Per-channel pending request, level, asynchronous |
| rotate_en | input | 1 | Rotating priority when high, fixed priority when low |
| fetch_gate_en | input | 1 | Defer each transfer to the next instruction fetch |
| fetch_stb | input | 1 | CPU instruction-fetch strobe |
| nmi | input | 1 | Non-maskable interrupt request |
| nmi_en | input | 1 | Allows an NMI to preempt a transfer |
| bus_done | input | 1 | The current bus cycle completes this clock |
| grant | output | 3 | One-hot channel grant |
| bus_hold | output | 1 | Stall request to the CPU |
| bus_rd | output | 1 | Read cycle in progress |
| bus_wr | output | 1 | Write cycle in progress |
| abort | output | 3 | One-cycle pulse naming a channel preempted by NMI |

## Verification
The assertions take `nmi`, `nmi_en`, `fetch_stb`, `fetch_gate_en` and `bus_done` to be synchronous to `clk`. They also take the two mode inputs to be steady for the whole of a transfer; only `chan_req` is treated as asynchronous. The stimulus changes every input only on the falling edge. It sets `rotate_en` and `fetch_gate_en` under reset before each scenario and does not touch them until the next reset. It raises `nmi` for a single cycle at a chosen read or write cycle.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    localparam int CH_COUNT = 3;
    localparam int CH_IDX_W = $clog2(CH_COUNT);

    typedef logic [CH_COUNT-1:0] ch_vec_t;
    typedef logic [CH_IDX_W-1:0] ch_idx_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_RD,
        ST_WR,
        ST_WAIT
    } seq_state_e;

    // Index of the set bit of a one-hot vector (zero for an empty vector).
    function automatic ch_idx_t vec_to_idx(ch_vec_t v);
        ch_idx_t r;
        r = '0;
        for (int i = 0; i < CH_COUNT; i++) begin
            if (v[i]) r = ch_idx_t'(i);
        end
        return r;
    endfunction

    // Cyclic successor of a channel index.
    function automatic ch_idx_t idx_after(ch_idx_t i);
        return (i == ch_idx_t'(CH_COUNT - 1)) ? '0 : i + ch_idx_t'(1);
    endfunction

endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick
    import dma_arb_pkg::*;
(
    input  ch_vec_t req,
    input  ch_idx_t top,
    output ch_vec_t win,
    output logic    any
);

    ch_idx_t pos;

    // Walk the channels cyclically starting at the highest-priority one.
    always_comb begin
        win = '0;
        any = 1'b0;
        pos = top;
        for (int off = 0; off < CH_COUNT; off++) begin
            if (!any && req[pos]) begin
                win[pos] = 1'b1;
                any      = 1'b1;
            end
            pos = idx_after(pos);
        end
    end

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
    import dma_arb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ch_vec_t pick_win,
    input  logic    pick_any,
    output ch_idx_t pick_top,
    input  logic    rotate_en,
    input  logic    fetch_gate_en,
    input  logic    fetch_stb,
    input  logic    nmi,
    input  logic    nmi_en,
    input  logic    bus_done,
    output ch_vec_t grant,
    output logic    bus_hold,
    output logic    bus_rd,
    output logic    bus_wr,
    output ch_vec_t abort_pls
);

    seq_state_e state_q, state_d;
    ch_vec_t    grant_q, grant_d;
    ch_vec_t    abort_q, abort_d;
    ch_idx_t    top_q, top_d;
    ch_idx_t    next_top;
    logic       preempt;
    seq_state_e launch_state;

    assign preempt      = nmi && nmi_en && (state_q == ST_RD || state_q == ST_WR);
    assign next_top     = rotate_en ? idx_after(vec_to_idx(grant_q)) : '0;
    assign launch_state = fetch_gate_en ? ST_ARM : ST_RD;
    assign pick_top     = (state_q == ST_WAIT) ? next_top : (rotate_en ? top_q : '0);

    always_comb begin
        state_d = state_q;
        grant_d = grant_q;
        top_d   = top_q;
        abort_d = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (pick_any) begin
                    state_d = launch_state;
                    grant_d = pick_win;
                end
            end
            ST_ARM: begin
                if (fetch_stb || !fetch_gate_en) state_d = ST_RD;
            end
            ST_RD, ST_WR: begin
                if (preempt) begin
                    state_d = ST_IDLE;
                    grant_d = '0;
                    abort_d = grant_q;
                end else if (bus_done) begin
                    state_d = (state_q == ST_RD) ? ST_WR : ST_WAIT;
                end
            end
            ST_WAIT: begin
                top_d = next_top;
                if (pick_any) begin
                    state_d = launch_state;
                    grant_d = pick_win;
                end else begin
                    state_d = ST_IDLE;
                    grant_d = '0;
                end
            end
            default: begin
                state_d = ST_IDLE;
                grant_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            grant_q <= '0;
            abort_q <= '0;
            top_q   <= '0;
        end else begin
            state_q <= state_d;
            grant_q <= grant_d;
            abort_q <= abort_d;
            top_q   <= top_d;
        end
    end

    assign grant     = grant_q;
    assign abort_pls = abort_q;
    assign bus_rd    = (state_q == ST_RD);
    assign bus_wr    = (state_q == ST_WR);
    assign bus_hold  = (state_q == ST_RD) || (state_q == ST_WR) || (state_q == ST_WAIT);

endmodule

// File: rtl/dma_tri_arbiter.sv
module dma_tri_arbiter
    import dma_arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] chan_req,
    input  logic       rotate_en,
    input  logic       fetch_gate_en,
    input  logic       fetch_stb,
    input  logic       nmi,
    input  logic       nmi_en,
    input  logic       bus_done,
    output logic [2:0] grant,
    output logic       bus_hold,
    output logic       bus_rd,
    output logic       bus_wr,
    output logic [2:0] abort
);

    ch_vec_t req_s;
    ch_vec_t pick_win;
    logic    pick_any;
    ch_idx_t pick_top;

    dma_req_sync #(
        .WIDTH (CH_COUNT),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (chan_req),
        .q  (req_s)
    );

    dma_prio_pick u_pick (
        .req(req_s),
        .top(pick_top),
        .win(pick_win),
        .any(pick_any)
    );

    dma_xfer_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .pick_win     (pick_win),
        .pick_any     (pick_any),
        .pick_top     (pick_top),
        .rotate_en    (rotate_en),
        .fetch_gate_en(fetch_gate_en),
        .fetch_stb    (fetch_stb),
        .nmi          (nmi),
        .nmi_en       (nmi_en),
        .bus_done     (bus_done),
        .grant        (grant),
        .bus_hold     (bus_hold),
        .bus_rd       (bus_rd),
        .bus_wr       (bus_wr),
        .abort_pls    (abort)
    );

endmodule

// File: rtl/dma_tri_arbiter_chk.sv
module dma_tri_arbiter_chk (
    input logic       clk,
    input logic       rst,
    input logic       fetch_gate_en,
    input logic       fetch_stb,
    input logic       nmi,
    input logic       nmi_en,
    input logic       bus_done,
    input logic [2:0] grant,
    input logic       bus_hold,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic [2:0] abort
);

    assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    assert_grant_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd || bus_wr) && !(nmi && nmi_en) |=> $stable(grant));

    assert_rd_then_wr_R6: assert property (@(posedge clk) disable iff (rst)
        bus_rd && bus_done && !(nmi && nmi_en) |=> bus_wr && !bus_rd);

    assert_wr_then_wait_R6: assert property (@(posedge clk) disable iff (rst)
        bus_wr && bus_done && !(nmi && nmi_en) |=> bus_hold && !bus_rd && !bus_wr);

    assert_hold_covers_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd || bus_wr) |-> bus_hold);

    assert_fetch_defer_R8: assert property (@(posedge clk) disable iff (rst)
        fetch_gate_en && (grant != 3'b000) && !bus_hold && !fetch_stb |=> !bus_rd);

    assert_abort_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd || bus_wr) && nmi && nmi_en |=> (abort == $past(grant)) && (grant == 3'b000));

    assert_no_abort_R10: assert property (@(posedge clk) disable iff (rst)
        !(nmi && nmi_en) |=> abort == 3'b000);

endmodule

bind dma_tri_arbiter dma_tri_arbiter_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .fetch_gate_en(fetch_gate_en),
    .fetch_stb    (fetch_stb),
    .nmi          (nmi),
    .nmi_en       (nmi_en),
    .bus_done     (bus_done),
    .grant        (grant),
    .bus_hold     (bus_hold),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .abort        (abort)
);

// File: tb/dma_tri_arbiter_bench.sv
module dma_tri_arbiter_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] chan_req;
    logic       rotate_en, fetch_gate_en, fetch_stb, nmi, nmi_en, bus_done;
    logic [2:0] grant, abort;
    logic       bus_hold, bus_rd, bus_wr;

    int n_checks = 0;
    int n_errs   = 0;

    always #4 clk = ~clk;

    dma_tri_arbiter u_dma_tri_arbiter (
        .clk(clk), .rst(rst), .chan_req(chan_req), .rotate_en(rotate_en),
        .fetch_gate_en(fetch_gate_en), .fetch_stb(fetch_stb), .nmi(nmi),
        .nmi_en(nmi_en), .bus_done(bus_done), .grant(grant), .bus_hold(bus_hold),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .abort(abort)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int pick(input int mask, input int top);
        for (int off = 0; off < 3; off++) begin
            if (((mask >> ((top + off) % 3)) & 1) != 0) return (top + off) % 3;
        end
        return -1;
    endfunction

    task automatic do_reset(input logic rot, input logic gate, input logic nen);
        @(negedge clk);
        rst = 1'b1; chan_req = '0; rotate_en = rot; fetch_gate_en = gate;
        fetch_stb = 1'b0; nmi = 1'b0; nmi_en = nen; bus_done = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // Waits for the next read cycle, returns its grant and the number of
    // falling edges spent waiting, then steps past the read cycle.
    task automatic next_read(output logic [2:0] g, output int waits);
        waits = 0;
        while (!bus_rd && waits < 40) begin
            @(negedge clk);
            waits++;
        end
        g = grant;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 100000);
        n_errs++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        logic [2:0] g;
        int waits;
        int top;
        int exp;

        // R1: reset state
        do_reset(1'b0, 1'b0, 1'b0);
        check({grant, abort, bus_hold, bus_rd, bus_wr} == 9'd0, "R1 reset outputs",
              int'({grant, abort, bus_hold, bus_rd, bus_wr}), 0);

        // R2 R3 R4 R11: sweep every request mask under both priority modes
        for (int rot = 0; rot < 2; rot++) begin
            for (int mask = 1; mask < 8; mask++) begin
                do_reset(logic'(rot), 1'b0, 1'b0);
                chan_req = mask[2:0];
                top = 0;
                for (int k = 0; k < 6; k++) begin
                    next_read(g, waits);
                    exp = pick(mask, top);
                    if (rot != 0) begin
                        check(int'(g) == (1 << exp), "R4 rotating grant", int'(g), 1 << exp);
                        top = (exp + 1) % 3;
                    end else begin
                        check(int'(g) == (1 << exp), "R3 fixed grant", int'(g), 1 << exp);
                    end
                    if (k == 0) check(waits == 3, "R2 sync latency", waits, 3);
                    else        check(waits == 2, "R11 back-to-back cadence", waits, 2);
                end
            end
        end

        // R6 R7: phase sequence and hold window
        do_reset(1'b0, 1'b0, 1'b0);
        chan_req = 3'b001;
        while (!bus_rd) @(negedge clk);
        check(bus_hold == 1'b1, "R7 hold in read", int'(bus_hold), 1);
        chan_req = 3'b000;
        @(negedge clk);
        check(bus_wr && !bus_rd && bus_hold, "R6 write follows read", int'({bus_rd, bus_wr}), 1);
        @(negedge clk);
        check(!bus_wr && !bus_rd && bus_hold && grant == 3'b001, "R6 single wait cycle",
              int'({bus_hold, bus_rd, bus_wr}), 4);
        repeat (12) @(negedge clk);
        check(!bus_hold && grant == 3'b000, "R7 hold low when idle", int'({bus_hold, grant}), 0);

        // R5 R6: stalled read cycle keeps grant and phase
        do_reset(1'b0, 1'b0, 1'b0);
        bus_done = 1'b0;
        chan_req = 3'b110;
        while (!bus_rd) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(bus_rd && !bus_wr && grant == 3'b010, "R5 grant held during stall",
                  int'(grant), 2);
        end
        bus_done = 1'b1;
        @(negedge clk);
        check(bus_wr && grant == 3'b010, "R6 write after stall", int'(bus_wr), 1);

        // R8: fetch gating defers the read cycle
        do_reset(1'b0, 1'b1, 1'b0);
        chan_req = 3'b010;
        while (grant == 3'b000) @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            check(!bus_rd && !bus_hold && grant == 3'b010, "R8 deferred until fetch",
                  int'({bus_rd, bus_hold}), 0);
            @(negedge clk);
        end
        fetch_stb = 1'b1;
        @(negedge clk);
        fetch_stb = 1'b0;
        check(bus_rd && bus_hold && grant == 3'b010, "R8 read after fetch strobe",
              int'(bus_rd), 1);

        // R9: NMI preempts in the read cycle
        do_reset(1'b0, 1'b0, 1'b1);
        chan_req = 3'b100;
        while (!bus_rd) @(negedge clk);
        nmi = 1'b1;
        @(negedge clk);
        nmi = 1'b0;
        check(abort == 3'b100 && grant == 3'b000 && !bus_hold, "R9 abort in read",
              int'(abort), 4);
        @(negedge clk);
        check(abort == 3'b000, "R9 abort is one cycle", int'(abort), 0);

        // R9: NMI preempts in the write cycle
        do_reset(1'b0, 1'b0, 1'b1);
        chan_req = 3'b001;
        while (!bus_wr) @(negedge clk);
        nmi = 1'b1;
        @(negedge clk);
        nmi = 1'b0;
        check(abort == 3'b001 && grant == 3'b000 && !bus_hold, "R9 abort in write",
              int'(abort), 1);

        // R10: NMI without enable has no effect
        do_reset(1'b0, 1'b0, 1'b0);
        chan_req = 3'b100;
        while (!bus_rd) @(negedge clk);
        nmi = 1'b1;
        @(negedge clk);
        check(bus_wr && grant == 3'b100 && abort == 3'b000, "R10 nmi ignored in read",
              int'({abort, bus_wr}), 1);
        @(negedge clk);
        nmi = 1'b0;
        check(bus_hold && !bus_wr && abort == 3'b000, "R10 transfer completes",
              int'({abort, bus_hold}), 1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule